// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A single register-mapped bank of 32 general-purpose lines, grouped as four 8-bit ports (port A holds lines 0-7 in byte lane 0, port B lines 8-15, port C lines 16-23 and port D lines 24-31). Software sets the direction of each line, drives an output latch and reads the line levels back. Inputs pass through a two-flop synchroniser before anything else uses them.

Every line can be armed to flag a falling edge, a rising edge or either edge. A detected edge sets a sticky bit in a status word. Software clears that bit by writing 1 to it. A single interrupt line to the host is high while any status bit is set. The host port is a plain 32-bit register bus with byte-lane enables, so byte, halfword and word writes all work. Reads are combinational from the word address.

Top module: `edge_gpio_bank`

## Requirements
- R1: After reset the direction, output latch, edge-select, status and pin-select words all read 0, `pin_oe` is 0 and `irq` is low.
- R2: Word offsets are: pin-select 0x00, direction 0x08, data 0x0C, status 0x10, edge-select for ports A/B 0x14, edge-select for ports C/D 0x18. The pin-select word is stored and read back but has no effect on `pin_oe`, `pin_out` or interrupts.
- R3: A direction bit of 1 makes the line an output (`pin_oe` bit high). A bit of 0 makes it an input. `pin_out` always shows the output latch, and writes to the data word update the latch for all 32 lines.
- R4: A data-word read returns the latch bit for output lines. For input lines it returns the synchronised level, which follows `pin_in` after two clock edges.
- R5: Each line n has a 2-bit edge field at bits 2*(n%8)+1:2*(n%8) of the 16-bit halfword for its port. The halfword for port p sits at offset 0x14+2*p. Codes: 00 no event, 01 falling edge, 10 rising edge, 11 either edge. A status bit is set only on an edge that matches its field.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: If an edge event and a clear of the same status bit land on the same clock edge, the bit ends up set.
- R8: `irq` is high exactly while at least one status bit is set.
- R9: Only the byte lanes whose `bus_be` bit is 1 are written. 8-bit and 16-bit writes leave the other lanes intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address (word select from bits 4:2) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Line levels from the pads |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Output enable (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench arms one line of port B with each of the four edge codes. It then drives rising and falling edges, which exposes a design that swaps the falling and rising code bits or packs the fields at the wrong offset. A port D line is programmed through a halfword write to the upper half of 0x18, so a design that mislocates port halfwords raises the wrong status bit. The bench times a clear to land on the same edge as a new event, and a design where the clear wins would drop the interrupt. It also writes zeros to status and uses partial-lane writes, and a design that ignored the rules would lose pending events or corrupt the neighbouring bytes.

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int FW = 2 * NPIN;

  logic [NPIN-1:0] psel_q, dir_q, lat_q, stat_q;
  logic [NPIN-1:0] sy1_q, sy2_q, sy3_q;
  logic [FW-1:0]   edg_q;
  logic [NPIN-1:0] rise, fall, hit, clr;

  wire        wen  = bus_sel & bus_wr;
  wire [2:0]  widx = bus_addr[4:2];
  wire [31:0] lane = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  wire [31:0] wm_psel = (wen && widx == 3'd0) ? lane : 32'd0;
  wire [31:0] wm_dir  = (wen && widx == 3'd2) ? lane : 32'd0;
  wire [31:0] wm_dat  = (wen && widx == 3'd3) ? lane : 32'd0;
  wire [31:0] wm_st   = (wen && widx == 3'd4) ? lane : 32'd0;
  wire [31:0] wm_elo  = (wen && widx == 3'd5) ? lane : 32'd0;
  wire [31:0] wm_ehi  = (wen && widx == 3'd6) ? lane : 32'd0;

  assign rise = sy2_q & ~sy3_q;
  assign fall = ~sy2_q & sy3_q;
  assign clr  = wm_st & bus_wdata;

  for (genvar n = 0; n < NPIN; n++) begin : g_hit
    assign hit[n] = (edg_q[2*n+1] & rise[n]) | (edg_q[2*n] & fall[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      dir_q  <= '0;
      lat_q  <= '0;
      stat_q <= '0;
      edg_q  <= '0;
      sy1_q  <= '0;
      sy2_q  <= '0;
      sy3_q  <= '0;
    end else begin
      sy1_q  <= pin_in;
      sy2_q  <= sy1_q;
      sy3_q  <= sy2_q;
      psel_q <= (psel_q & ~wm_psel) | (bus_wdata & wm_psel);
      dir_q  <= (dir_q & ~wm_dir) | (bus_wdata & wm_dir);
      lat_q  <= (lat_q & ~wm_dat) | (bus_wdata & wm_dat);
      edg_q[31:0]  <= (edg_q[31:0] & ~wm_elo) | (bus_wdata & wm_elo);
      edg_q[63:32] <= (edg_q[63:32] & ~wm_ehi) | (bus_wdata & wm_ehi);
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  always_comb begin
    case (widx)
      3'd0:    bus_rdata = psel_q;
      3'd2:    bus_rdata = dir_q;
      3'd3:    bus_rdata = (dir_q & lat_q) | (~dir_q & sy2_q);
      3'd4:    bus_rdata = stat_q;
      3'd5:    bus_rdata = edg_q[31:0];
      3'd6:    bus_rdata = edg_q[63:32];
      default: bus_rdata = 32'd0;
    endcase
  end

  assign pin_out = lat_q;
  assign pin_oe  = dir_q;
  assign irq     = |stat_q;

  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> ((stat_q & $past(clr)) == '0));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr != '0));
  assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_dir == 32'd0) |=> $stable(pin_oe));
endmodule

// File: tb/edge_gpio_bank_bench.sv
module edge_gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  edge_gpio_bank u_edge_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = '0;
  endtask

  task automatic brd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      brd(5'(a * 4), v);
      chk("R1 reg after reset", v, 32'd0);
    end
    chk("R1 pin_oe", pin_oe, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_pinsel;
    logic [31:0] v;
    bwr(5'h00, 4'hF, 32'hFFFF_FFFF);
    brd(5'h00, v);
    chk("R2 pin-select readback", v, 32'hFFFF_FFFF);
    chk("R2 pin-select no oe effect", pin_oe, 32'd0);
    chk("R2 pin-select no out effect", pin_out, 32'd0);
    chk("R2 pin-select no irq", {31'd0, irq}, 32'd0);
    bwr(5'h00, 4'hF, 32'd0);
  endtask

  task automatic t_dir_data;
    logic [31:0] v;
    pin_in = 32'h5A5A_0000;
    bwr(5'h0C, 4'hF, 32'hA5A5_1234);
    bwr(5'h08, 4'hF, 32'h0000_FFFF);
    chk("R3 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R3 pin_out shows all latch", pin_out, 32'hA5A5_1234);
    idle(3);
    brd(5'h0C, v);
    chk("R4 data mix", v, 32'h5A5A_1234);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    @(negedge clk);
    pin_in = 32'h0F0F_0000;
    @(negedge clk);
    #1 v = bus_rdata;
    chk("R4 one edge: old level", v, 32'h5A5A_1234);
    @(negedge clk);
    #1 v = bus_rdata;
    chk("R4 two edges: new level", v, 32'h0F0F_1234);
    pin_in = 32'd0;
    bwr(5'h08, 4'hF, 32'd0);
    bwr(5'h0C, 4'hF, 32'd0);
    idle(4);
  endtask

  task automatic t_edge_modes;
    logic [31:0] v;
    bwr(5'h14, 4'b0100, 32'h00E4_0000);
    brd(5'h14, v);
    chk("R5 port B fields", v, 32'h00E4_0000);
    @(negedge clk);
    pin_in[11:8] = 4'hF;
    idle(4);
    brd(5'h10, v);
    chk("R5 rising: codes 10 and 11", v, 32'h0000_0C00);
    bwr(5'h10, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk);
    pin_in[11:8] = 4'h0;
    idle(4);
    brd(5'h10, v);
    chk("R5 falling: codes 01 and 11", v, 32'h0000_0A00);
    chk("R8 irq high", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    bwr(5'h10, 4'hF, 32'h0000_0200);
    brd(5'h10, v);
    chk("R6 clear one bit", v, 32'h0000_0800);
    bwr(5'h10, 4'hF, 32'd0);
    brd(5'h10, v);
    chk("R6 write 0 keeps", v, 32'h0000_0800);
    chk("R8 irq still high", {31'd0, irq}, 32'd1);
    bwr(5'h10, 4'hF, 32'h0000_0800);
    brd(5'h10, v);
    chk("R6 all cleared", v, 32'd0);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_port_d;
    logic [31:0] v;
    bwr(5'h18, 4'b1100, 32'h2000_0000);
    brd(5'h18, v);
    chk("R5 port D halfword", v, 32'h2000_0000);
    @(negedge clk);
    pin_in[30] = 1'b1;
    idle(4);
    brd(5'h10, v);
    chk("R5 port D rising line 30", v, 32'h4000_0000);
    bwr(5'h10, 4'hF, 32'h4000_0000);
    @(negedge clk);
    pin_in[30] = 1'b0;
    idle(4);
    brd(5'h10, v);
    chk("R5 rising-only ignores fall", v, 32'd0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    bwr(5'h14, 4'b0001, 32'h0000_0003);
    @(negedge clk);
    pin_in[0] = 1'b1;
    idle(4);
    brd(5'h10, v);
    chk("R5 both-edge rise", v, 32'h0000_0001);
    @(negedge clk);
    pin_in[0] = 1'b0;
    @(negedge clk);
    bwr(5'h10, 4'hF, 32'h0000_0001);
    brd(5'h10, v);
    chk("R7 set wins over clear", v, 32'h0000_0001);
    chk("R8 irq kept", {31'd0, irq}, 32'd1);
    bwr(5'h10, 4'hF, 32'h0000_0001);
    brd(5'h10, v);
    chk("R6 later clear", v, 32'd0);
  endtask

  task automatic t_strobes;
    logic [31:0] v;
    bwr(5'h08, 4'b0001, 32'hFFFF_FFFF);
    brd(5'h08, v);
    chk("R9 byte write lane 0", v, 32'h0000_00FF);
    bwr(5'h08, 4'b1100, 32'h1234_5678);
    brd(5'h08, v);
    chk("R9 halfword write upper", v, 32'h1234_00FF);
    bwr(5'h08, 4'b0000, 32'hFFFF_FFFF);
    brd(5'h08, v);
    chk("R9 no lanes no change", v, 32'h1234_00FF);
    chk("R3 oe follows dir", pin_oe, 32'h1234_00FF);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_pinsel;
    t_dir_data;
    t_sync;
    t_edge_modes;
    t_w1c;
    t_port_d;
    t_set_wins;
    t_strobes;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule